// File: doc/BRIEF.md
# Delay-Slot Next-PC Unit

This block chooses the next fetch address for a five-stage pipeline whose jumps and branches have an architectural delay slot. The instruction that follows a control transfer always runs, so the block never asks for a flush. Every target it forms is based on the delay-slot address, which is the control instruction's own address plus 4. Each cycle the decode stage hands over a valid strobe and the primary and function opcode fields. It also hands over the 26-bit jump index, the 16-bit immediate, the rd field, the delay-slot address, the current sequential fetch address, and both register operands.

One cycle later the block presents the registered next fetch address and a taken flag. These steer the fetch that comes after the delay slot. At the same time it presents a link-write request for the register file, made of an enable, a destination and a value, and a flag for any control opcode in the map that this unit does not carry out. It handles direct jumps, register jumps, their linking forms, and four compare-based branches. Any instruction that is not a control transfer simply advances the fetch address by 4.

Top module: `ctl_next_pc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs are next_pc = 0, taken = 0, link_we = 0, link_rd = 0, link_val = 0 and unsup = 0.
- R2: A valid direct jump (opcode 000010) gives taken = 1 one cycle later. Its next_pc is bits 31..28 of the delay-slot address, then the 26-bit index, then two zero bits.
- R3: The target of a taken branch is the delay-slot address plus the sign-extended 16-bit immediate multiplied by 4, computed modulo 2^32.
- R4: Opcode 000100 is taken when rs equals rt. Opcode 000101 is taken when rs and rt differ.
- R5: Opcode 000110 is taken when rs, read as signed, is at most zero. Opcode 000111 is taken when signed rs is greater than zero. For both, rt has no effect.
- R6: A register jump (opcode 000000 with function 001000 or 001001) is always taken, and next_pc is the full 32-bit rs value.
- R7: Opcode 000011 jumps like R2. In the same cycle it raises link_we with link_rd = 31 and link_val = delay-slot address + 4.
- R8: Function 001001 under opcode 000000 raises link_we with link_rd equal to the rd field and link_val = delay-slot address + 4.
- R9: When nothing is taken, next_pc = sequential fetch address + 4 and taken = 0. When link_we is 0, link_rd and link_val are 0.
- R10: Unsupported control opcodes raise unsup and are neither taken nor linked. These are 000001, 010100 through 010111, and 011101. No other opcode raises unsup.
- R11: Opcode 000000 with any function other than 001000 and 001001 acts as a sequential instruction and does not raise unsup.
- R12: When valid is low, the fields are ignored. The result is sequential: taken, link_we and unsup are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decode-stage instruction valid |
| opcode | input | 6 | Primary opcode, instruction bits 31..26 |
| funct | input | 6 | Function field, instruction bits 5..0 |
| index | input | 26 | Direct-jump index field |
| imm | input | 16 | Branch immediate |
| rd | input | 5 | rd field, used as the register-jump link destination |
| slot_pc | input | 32 | Delay-slot address (control address + 4) |
| seq_pc | input | 32 | Current sequential fetch address |
| rs_val | input | 32 | rs operand |
| rt_val | input | 32 | rt operand |
| next_pc | output | 32 | Registered next fetch address |
| taken | output | 1 | Registered control-transfer-taken flag |
| link_we | output | 1 | Registered link write enable |
| link_rd | output | 5 | Registered link destination register |
| link_val | output | 32 | Registered link value |
| unsup | output | 1 | Registered unsupported-control-opcode flag |

## Verification
Two cases are the hardest to reach from the ports, and both involve targets that cross a boundary. In the first, a direct jump's delay slot falls in the next 256 MB region, so the retained upper bits must come from the slot address and not from the jump's own address. In the second, a branch offset wraps the address space. The stimulus reaches both by driving slot_pc directly with values such as 0x10000000, 0xFFFFFFFC and 0, crossed with the extreme immediates 0x7FFF and 0x8000. The sign boundaries of the compare branches are swept as well, including 0, -1 and 0x80000000, together with every primary opcode and every function code under opcode 000000.

// File: rtl/ctl_npc_pkg.sv
package ctl_npc_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned IDX_W   = 26;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned REGION_W = XLEN - IDX_W - 2;
  localparam int unsigned INSN_BYTES = 4;

  localparam logic [OP_W-1:0] OPC_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0] OPC_REGIMM  = 6'b000001;
  localparam logic [OP_W-1:0] OPC_JMP     = 6'b000010;
  localparam logic [OP_W-1:0] OPC_JMPL    = 6'b000011;
  localparam logic [OP_W-1:0] OPC_BEQ     = 6'b000100;
  localparam logic [OP_W-1:0] OPC_BNE     = 6'b000101;
  localparam logic [OP_W-1:0] OPC_BLEZ    = 6'b000110;
  localparam logic [OP_W-1:0] OPC_BGTZ    = 6'b000111;
  localparam logic [OP_W-1:0] OPC_JLX     = 6'b011101;
  localparam logic [3:0]      OPC_LIKELY_HI = 4'b0101;

  localparam logic [OP_W-1:0] FN_JREG  = 6'b001000;
  localparam logic [OP_W-1:0] FN_JREGL = 6'b001001;

  typedef enum logic [2:0] {
    CLS_SEQ,
    CLS_JIMM,
    CLS_JREG,
    CLS_BR_EQ,
    CLS_BR_NE,
    CLS_BR_LEZ,
    CLS_BR_GTZ,
    CLS_UNSUP
  } ctl_cls_e;

  function automatic logic [XLEN-1:0] f_region_target(
    input logic [XLEN-1:0]  slot,
    input logic [IDX_W-1:0] idx
  );
    return {slot[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] f_rel_target(
    input logic [XLEN-1:0]  slot,
    input logic [IMM_W-1:0] off
  );
    logic [XLEN-1:0] sext;
    sext = {{(XLEN-IMM_W-2){off[IMM_W-1]}}, off, 2'b00};
    return slot + sext;
  endfunction

  function automatic logic f_signed_lez(input logic [XLEN-1:0] v);
    return v[XLEN-1] || (v == '0);
  endfunction

  function automatic logic [XLEN-1:0] f_step(input logic [XLEN-1:0] a);
    return a + XLEN'(INSN_BYTES);
  endfunction

endpackage

// File: rtl/ctl_npc_decode.sv
module ctl_npc_decode
  import ctl_npc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [OP_W-1:0] funct,
  output ctl_cls_e        cls,
  output logic            link_en,
  output logic            link_to_rd
);

  always_comb begin
    cls        = CLS_SEQ;
    link_en    = 1'b0;
    link_to_rd = 1'b0;
    unique case (opcode)
      OPC_SPECIAL: begin
        if (funct == FN_JREG) begin
          cls = CLS_JREG;
        end else if (funct == FN_JREGL) begin
          cls        = CLS_JREG;
          link_en    = 1'b1;
          link_to_rd = 1'b1;
        end
      end
      OPC_JMP:  cls = CLS_JIMM;
      OPC_JMPL: begin
        cls     = CLS_JIMM;
        link_en = 1'b1;
      end
      OPC_BEQ:  cls = CLS_BR_EQ;
      OPC_BNE:  cls = CLS_BR_NE;
      OPC_BLEZ: cls = CLS_BR_LEZ;
      OPC_BGTZ: cls = CLS_BR_GTZ;
      OPC_REGIMM, OPC_JLX: cls = CLS_UNSUP;
      default: begin
        if (opcode[OP_W-1:2] == OPC_LIKELY_HI) cls = CLS_UNSUP;
      end
    endcase
  end

endmodule

// File: rtl/ctl_npc_cond.sv
module ctl_npc_cond
  import ctl_npc_pkg::*;
(
  input  ctl_cls_e        cls,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            is_branch,
  output logic            cond_ok
);

  logic same;
  logic lez;

  assign same = (rs_val == rt_val);
  assign lez  = f_signed_lez(rs_val);

  always_comb begin
    is_branch = 1'b1;
    cond_ok   = 1'b0;
    case (cls)
      CLS_BR_EQ:  cond_ok = same;
      CLS_BR_NE:  cond_ok = !same;
      CLS_BR_LEZ: cond_ok = lez;
      CLS_BR_GTZ: cond_ok = !lez;
      default:    is_branch = 1'b0;
    endcase
  end

endmodule

// File: rtl/ctl_npc_target.sv
module ctl_npc_target
  import ctl_npc_pkg::*;
(
  input  ctl_cls_e         cls,
  input  logic [XLEN-1:0]  slot_pc,
  input  logic [IDX_W-1:0] index,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  rs_val,
  output logic [XLEN-1:0]  tgt
);

  logic [XLEN-1:0] tgt_region;
  logic [XLEN-1:0] tgt_rel;

  assign tgt_region = f_region_target(slot_pc, index);
  assign tgt_rel    = f_rel_target(slot_pc, imm);

  always_comb begin
    case (cls)
      CLS_JIMM: tgt = tgt_region;
      CLS_JREG: tgt = rs_val;
      default:  tgt = tgt_rel;
    endcase
  end

endmodule

// File: rtl/ctl_next_pc.sv
module ctl_next_pc
  import ctl_npc_pkg::*;
#(
  parameter logic [REG_W-1:0] LINK_REG = 5'd31,
  parameter logic [XLEN-1:0]  RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  opcode,
  input  logic [OP_W-1:0]  funct,
  input  logic [IDX_W-1:0] index,
  input  logic [IMM_W-1:0] imm,
  input  logic [REG_W-1:0] rd,
  input  logic [XLEN-1:0]  slot_pc,
  input  logic [XLEN-1:0]  seq_pc,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  next_pc,
  output logic             taken,
  output logic             link_we,
  output logic [REG_W-1:0] link_rd,
  output logic [XLEN-1:0]  link_val,
  output logic             unsup
);

  ctl_cls_e        dec_cls;
  logic            dec_link;
  logic            dec_link_rd;
  logic            br_is;
  logic            br_ok;
  logic [XLEN-1:0] tgt_addr;

  logic            take_c;
  logic [XLEN-1:0] pc_c;
  logic            we_c;
  logic [REG_W-1:0] rd_c;
  logic [XLEN-1:0] val_c;
  logic            unsup_c;

  ctl_npc_decode u_dec (
    .opcode     (opcode),
    .funct      (funct),
    .cls        (dec_cls),
    .link_en    (dec_link),
    .link_to_rd (dec_link_rd)
  );

  ctl_npc_cond u_cond (
    .cls       (dec_cls),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .is_branch (br_is),
    .cond_ok   (br_ok)
  );

  ctl_npc_target u_tgt (
    .cls     (dec_cls),
    .slot_pc (slot_pc),
    .index   (index),
    .imm     (imm),
    .rs_val  (rs_val),
    .tgt     (tgt_addr)
  );

  always_comb begin
    take_c  = in_valid && ((dec_cls == CLS_JIMM) || (dec_cls == CLS_JREG) ||
                           (br_is && br_ok));
    pc_c    = take_c ? tgt_addr : f_step(seq_pc);
    we_c    = in_valid && dec_link;
    rd_c    = '0;
    val_c   = '0;
    if (we_c) begin
      rd_c  = dec_link_rd ? rd : LINK_REG;
      val_c = f_step(slot_pc);
    end
    unsup_c = in_valid && (dec_cls == CLS_UNSUP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc  <= RESET_PC;
      taken    <= 1'b0;
      link_we  <= 1'b0;
      link_rd  <= '0;
      link_val <= '0;
      unsup    <= 1'b0;
    end else begin
      next_pc  <= pc_c;
      taken    <= take_c;
      link_we  <= we_c;
      link_rd  <= rd_c;
      link_val <= val_c;
      unsup    <= unsup_c;
    end
  end

endmodule

// File: rtl/ctl_next_pc_sva.sv
module ctl_next_pc_sva
  import ctl_npc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [OP_W-1:0]  opcode,
  input logic [OP_W-1:0]  funct,
  input logic [IDX_W-1:0] index,
  input logic [IMM_W-1:0] imm,
  input logic [REG_W-1:0] rd,
  input logic [XLEN-1:0]  slot_pc,
  input logic [XLEN-1:0]  seq_pc,
  input logic [XLEN-1:0]  rs_val,
  input logic [XLEN-1:0]  rt_val,
  input logic [XLEN-1:0]  next_pc,
  input logic             taken,
  input logic             link_we,
  input logic [REG_W-1:0] link_rd,
  input logic [XLEN-1:0]  link_val,
  input logic             unsup,
  input logic             br_ok
);

  // R1: reset values hold while reset is low
  always @(posedge clk)
    if (!rst_n) a_r1_reset_quiet: assert (!taken && !link_we && !unsup);

  a_r2_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_JMP) |=>
      (taken && next_pc == {$past(slot_pc[XLEN-1:XLEN-4]), $past(index), 2'b00}));

  a_r4_beq_follows_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == OPC_BEQ || opcode == OPC_BNE)) |=> (taken == $past(br_ok)));

  a_r3_beq_target: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_BEQ && rs_val == rt_val) |=>
      (next_pc == $past(slot_pc) + {{(XLEN-IMM_W-2){$past(imm[IMM_W-1])}}, $past(imm), 2'b00}));

  a_r6_jr_target: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_SPECIAL && funct == FN_JREG) |=>
      (taken && !link_we && next_pc == $past(rs_val)));

  a_r7_jal_link: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_JMPL) |=>
      (link_we && link_rd == 5'd31 && link_val == $past(slot_pc) + 32'd4));

  a_r8_jalr_link: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_SPECIAL && funct == FN_JREGL) |=>
      (link_we && link_rd == $past(rd)));

  a_r10_unsup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |-> (!taken && !link_we));

  a_r12_idle_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> (!taken && !link_we && !unsup && next_pc == $past(seq_pc) + 32'd4));

endmodule

bind ctl_next_pc ctl_next_pc_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .opcode   (opcode),
  .funct    (funct),
  .index    (index),
  .imm      (imm),
  .rd       (rd),
  .slot_pc  (slot_pc),
  .seq_pc   (seq_pc),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .next_pc  (next_pc),
  .taken    (taken),
  .link_we  (link_we),
  .link_rd  (link_rd),
  .link_val (link_val),
  .unsup    (unsup),
  .br_ok    (br_ok)
);

// File: tb/ctl_next_pc_tb.sv
`timescale 1ns/1ps
module ctl_next_pc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [25:0] index = '0;
  logic [15:0] imm = '0;
  logic [4:0]  rd = '0;
  logic [31:0] slot_pc = '0;
  logic [31:0] seq_pc = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] next_pc;
  logic        taken;
  logic        link_we;
  logic [4:0]  link_rd;
  logic [31:0] link_val;
  logic        unsup;

  int checks = 0;
  int fails  = 0;

  logic [31:0] e_pc;
  logic        e_tk;
  logic        e_we;
  logic [4:0]  e_rd;
  logic [31:0] e_val;
  logic        e_un;

  always #2.5 clk = ~clk;

  ctl_next_pc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .funct(funct),
    .index(index), .imm(imm), .rd(rd), .slot_pc(slot_pc), .seq_pc(seq_pc),
    .rs_val(rs_val), .rt_val(rt_val), .next_pc(next_pc), .taken(taken),
    .link_we(link_we), .link_rd(link_rd), .link_val(link_val), .unsup(unsup)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h (op=%b fn=%b)", tag, what, got, exp,
               opcode, funct);
    end
  endtask

  task automatic model();
    int signed off;
    e_tk = 1'b0; e_we = 1'b0; e_rd = '0; e_val = '0; e_un = 1'b0;
    e_pc = seq_pc + 32'd4;
    if (in_valid) begin
      off = 32'($signed(imm)) * 4;
      case (int'(opcode))
        2, 3: begin
          e_tk = 1'b1;
          e_pc = (slot_pc & 32'hF000_0000) | ({6'd0, index} * 32'd4);
          if (opcode == 6'd3) begin e_we = 1'b1; e_rd = 5'd31; e_val = slot_pc + 32'd4; end
        end
        4: e_tk = (rs_val == rt_val);
        5: e_tk = (rs_val != rt_val);
        6: e_tk = ($signed(rs_val) <= 0);
        7: e_tk = ($signed(rs_val) > 0);
        0: begin
          if (funct == 6'd8 || funct == 6'd9) begin e_tk = 1'b1; e_pc = rs_val; end
          if (funct == 6'd9) begin e_we = 1'b1; e_rd = rd; e_val = slot_pc + 32'd4; end
        end
        1, 20, 21, 22, 23, 29: e_un = 1'b1;
        default: ;
      endcase
      if (e_tk && opcode >= 6'd4 && opcode <= 6'd7) e_pc = slot_pc + 32'(off);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [5:0] op,
                      input logic [5:0] fn, input logic [25:0] ix, input logic [15:0] im,
                      input logic [4:0] r, input logic [31:0] sl, input logic [31:0] sq,
                      input logic [31:0] a, input logic [31:0] b);
    in_valid = v; opcode = op; funct = fn; index = ix; imm = im; rd = r;
    slot_pc = sl; seq_pc = sq; rs_val = a; rt_val = b;
    model();
    @(negedge clk);
    chk(tag, "next_pc", next_pc, e_pc);
    chk(tag, "taken", {31'd0, taken}, {31'd0, e_tk});
    chk(tag, "link_we", {31'd0, link_we}, {31'd0, e_we});
    chk(tag, "link_rd", {27'd0, link_rd}, {27'd0, e_rd});
    chk(tag, "link_val", link_val, e_val);
    chk(tag, "unsup", {31'd0, unsup}, {31'd0, e_un});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  logic [31:0] vals  [5] = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
  logic [15:0] imms  [5] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};
  logic [31:0] slots [3] = '{32'h0040_0004, 32'hFFFF_FFFC, 32'h0000_0000};
  logic [31:0] jslot [3] = '{32'h1000_0000, 32'hF000_0008, 32'h0040_0010};
  logic [25:0] idxs  [3] = '{26'd0, 26'h3FF_FFFF, 26'h123_4567};
  logic [4:0]  rds   [3] = '{5'd0, 5'd31, 5'd17};

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset values
    repeat (2) @(negedge clk);
    chk("R1", "next_pc", next_pc, 32'd0);
    chk("R1", "taken", {31'd0, taken}, 32'd0);
    chk("R1", "link_we", {31'd0, link_we}, 32'd0);
    chk("R1", "unsup", {31'd0, unsup}, 32'd0);
    in_valid = 1'b1; opcode = 6'd2; index = 26'h3FF_FFFF; slot_pc = 32'hF000_0000;
    @(negedge clk);
    chk("R1", "link_val", link_val, 32'd0);
    chk("R1", "next_pc_held", next_pc, 32'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "first_after_reset", {31'd0, taken}, 32'd0);

    // R10/R2/R4/R5/R7: sweep of every primary opcode
    for (int op = 0; op < 64; op++)
      step("R10", 1'b1, 6'(op), 6'd0, 26'h00A_BCDE, 16'h0010, 5'd3,
           32'h0040_0104, 32'h0040_0108, 32'd5, 32'd5);
    // R11/R6/R8: sweep of every function code under opcode 0
    for (int fn = 0; fn < 64; fn++)
      step("R11", 1'b1, 6'd0, 6'(fn), 26'd0, 16'd0, 5'd9,
           32'h0000_2000, 32'h0000_2004, 32'h1234_5678, 32'd0);

    // R3/R4/R5/R9: branch sweep across operands, offsets, slot addresses
    for (int op = 4; op < 8; op++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
          for (int i = 0; i < 5; i++)
            for (int s = 0; s < 3; s++)
              step((op < 6) ? "R3/R4/R9" : "R3/R5/R9", 1'b1, 6'(op), 6'd0, 26'd0,
                   imms[i], 5'd0, slots[s], slots[s] + 32'd4, vals[a], vals[b]);

    // R2/R7: direct jumps across region boundaries
    for (int j = 0; j < 2; j++)
      for (int s = 0; s < 3; s++)
        for (int x = 0; x < 3; x++)
          step((j == 0) ? "R2" : "R7", 1'b1, 6'(2 + j), 6'd0, idxs[x], 16'hFFFF,
               5'd4, jslot[s], jslot[s] + 32'd4, 32'hDEAD_BEEF, 32'd0);

    // R6/R8: register jumps
    for (int f = 8; f < 10; f++)
      for (int a = 0; a < 5; a++)
        for (int r = 0; r < 3; r++)
          step((f == 8) ? "R6" : "R8", 1'b1, 6'd0, 6'(f), 26'd0, 16'd0, rds[r],
               slots[r], slots[r] + 32'd4, vals[a], 32'd0);

    // R12: valid low ignores fields
    for (int op = 0; op < 8; op++)
      step("R12", 1'b0, 6'(op), 6'd9, 26'h3FF_FFFF, 16'h8000, 5'd7,
           32'h0000_0100, 32'h0000_0200, 32'd0, 32'd0);
    step("R12", 1'b0, 6'd1, 6'd0, 26'd0, 16'd0, 5'd0, 32'd0, 32'hFFFF_FFFC, 32'd0, 32'd1);

    finish_run();
  end

endmodule